// File: doc/BRIEF.md
# Binary Field Moving-Average Oversampler

This block turns a stream of single-bit photon-detection fields into grey-level frames. Each pixel keeps a record of its most recent binary samples, one per field, plus a running count of how many of them are ones. The count therefore behaves as a sliding-window sum, which is a finite impulse response filter with as many taps as the oversampling ratio (OSR). For every field that comes in, one frame of counts goes out, so the output frame rate equals the field rate whatever OSR is chosen. A larger OSR gives more grey levels, about log2(OSR) bits, but it widens the time window and adds lag on moving content.

Pixels arrive in raster order, one per cycle that has the valid strobe high. A start-of-field strobe marks the first pixel of each field. Every accepted pixel does a single-cycle read-modify-write of its history slot and its count. The new count leaves the block one cycle later, tagged with a start marker and a flag that tells whether the window has filled. The pixel count and OSR are parameters. The count is ceil(log2(OSR+1)) bits wide, so a window of all ones can be held without wrapping.

Top module: `binfield_oversampler`

## Requirements
- R1: While reset is asserted and on the first cycle after it, out_valid, out_sof, out_full and out_count are all zero.
- R2: Each accepted pixel produces exactly one output beat one cycle later. out_sof is 1 on that beat exactly when the input pixel carried the start-of-field strobe.
- R3: The count for pixel p in field f equals the number of ones that pixel received in fields max(0, f-OSR+1) through f, the current field included. Fields are counted since the last reset.
- R4: If the bit entering a pixel's window equals the bit leaving it, that pixel's count is the same as in the previous field.
- R5: A pixel that receives a one in OSR or more consecutive fields reports exactly OSR. The count never exceeds OSR and never wraps.
- R6: out_full is 0 for every pixel of the first OSR-1 fields after reset. It is 1 for every pixel from field number OSR onward.
- R7: Pixels that are strobed valid before the first start-of-field after reset produce no output and change no stored state.
- R8: Pixels beyond position NUM_PIX-1 within a field produce no output and change no stored state.
- R9: A cycle with pix_valid low produces no output beat on the following cycle and changes no state.
- R10: A reset in the middle of a run clears every history bit, every count and the field tally. Counting then restarts as in R3 and R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | A pixel is present this cycle |
| pix_sof | input | 1 | Marks the first pixel of a field (used with pix_valid) |
| pix_bit | input | 1 | Binary photon detection for this pixel |
| out_valid | output | 1 | An output count is present |
| out_sof | output | 1 | The output count belongs to the first pixel of a frame |
| out_count | output | CW = ceil(log2(OSR+1)) | Sliding-window count of ones for the pixel |
| out_full | output | 1 | OSR fields have been received since reset |

## Verification
The assertions assume that every field begins with a single pixel carrying both pix_valid and pix_sof, and that pixels follow in raster order. They also assume that pix_sof is never raised without pix_valid. The stimulus follows these rules for every field it sends. Where it sends stray pixels, before the first field or past the end of a row, it raises pix_valid alone without the start strobe. The bench is built with a small pixel count and an OSR that is not a power of two. It sweeps all-ones, all-zeros, alternating and scrambled bit patterns for more fields than the window holds, so both the ramp-up phase and the wrapped phase of the history are covered.

// File: rtl/bfo_pkg.sv
package bfo_pkg;

  // Bits needed for an up-to-and-including count of n
  function automatic int unsigned count_bits(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // Bits needed to address n entries
  function automatic int unsigned addr_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Sliding-window step: add entering bit, remove leaving bit
  function automatic int unsigned window_step(input int unsigned cur,
                                              input logic enter,
                                              input logic leave);
    return cur + {31'd0, enter} - {31'd0, leave};
  endfunction

  // Circular slot advance
  function automatic int unsigned slot_advance(input int unsigned cur,
                                               input int unsigned depth);
    return (cur + 1 >= depth) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/bfo_raster_track.sv
module bfo_raster_track #(
  parameter int unsigned NUM_PIX = 16,
  parameter int unsigned OSR     = 8,
  localparam int unsigned IW = bfo_pkg::count_bits(NUM_PIX),
  localparam int unsigned SW = bfo_pkg::addr_bits(OSR),
  localparam int unsigned FW = bfo_pkg::count_bits(OSR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_valid,
  input  logic          pix_sof,
  output logic          accept,
  output logic [IW-1:0] cur_idx,
  output logic [SW-1:0] cur_slot,
  output logic          cur_full
);
  localparam logic [IW-1:0] PIX_END = IW'(NUM_PIX);
  localparam logic [FW-1:0] FLD_MAX = FW'(OSR);

  logic          active_q;
  logic [IW-1:0] pidx_q;
  logic [SW-1:0] slot_q;
  logic [FW-1:0] nfld_q;

  logic          field_start;
  logic          active_now;
  logic [FW-1:0] nfld_c;

  assign field_start = pix_valid && pix_sof;
  assign active_now  = active_q || field_start;

  always_comb begin
    cur_idx  = field_start ? '0 : pidx_q;
    cur_slot = slot_q;
    nfld_c   = nfld_q;
    if (field_start) begin
      cur_slot = (nfld_q == '0) ? '0
               : SW'(bfo_pkg::slot_advance(32'(slot_q), OSR));
      nfld_c   = (nfld_q == FLD_MAX) ? FLD_MAX : nfld_q + 1'b1;
    end
  end

  assign accept   = pix_valid && active_now && (cur_idx < PIX_END);
  assign cur_full = (nfld_c == FLD_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pidx_q   <= '0;
      slot_q   <= '0;
      nfld_q   <= '0;
    end else begin
      if (field_start) begin
        active_q <= 1'b1;
        slot_q   <= cur_slot;
        nfld_q   <= nfld_c;
      end
      if (pix_valid && active_now)
        pidx_q <= (cur_idx == PIX_END) ? PIX_END : cur_idx + 1'b1;
    end
  end

  // R8
  pix_index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pidx_q <= PIX_END);

  // R3
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(slot_q) < OSR);

  // R6
  full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nfld_q == FLD_MAX) |=> (nfld_q == FLD_MAX));

  // R7
  accept_needs_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_sof && !active_q) |-> !accept);

endmodule

// File: rtl/bfo_history.sv
module bfo_history #(
  parameter int unsigned NUM_PIX = 16,
  parameter int unsigned OSR     = 8,
  localparam int unsigned IW = bfo_pkg::count_bits(NUM_PIX),
  localparam int unsigned SW = bfo_pkg::addr_bits(OSR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] idx,
  input  logic [SW-1:0] slot,
  input  logic          new_bit,
  output logic          leave_bit
);
  logic [OSR-1:0] rows [NUM_PIX];

  for (genvar p = 0; p < NUM_PIX; p++) begin : g_row
    logic [OSR-1:0] row_q;
    logic           hit;
    assign hit = wr_en && (idx == IW'(p));
    always_ff @(posedge clk) begin
      if (!rst_n)   row_q       <= '0;
      else if (hit) row_q[slot] <= new_bit;
    end
    assign rows[p] = row_q;
  end

  always_comb begin
    leave_bit = 1'b0;
    for (int p = 0; p < NUM_PIX; p++)
      if (idx == IW'(p)) leave_bit = rows[p][slot];
  end

endmodule

// File: rtl/bfo_counts.sv
module bfo_counts #(
  parameter int unsigned NUM_PIX = 16,
  parameter int unsigned OSR     = 8,
  localparam int unsigned IW = bfo_pkg::count_bits(NUM_PIX),
  localparam int unsigned CW = bfo_pkg::count_bits(OSR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] idx,
  input  logic          enter_bit,
  input  logic          leave_bit,
  output logic [CW-1:0] old_count,
  output logic [CW-1:0] new_count
);
  logic [CW-1:0] cnts [NUM_PIX];

  for (genvar p = 0; p < NUM_PIX; p++) begin : g_cnt
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                            cnt_q <= '0;
      else if (wr_en && (idx == IW'(p)))     cnt_q <= new_count;
    end
    assign cnts[p] = cnt_q;
  end

  always_comb begin
    old_count = '0;
    for (int p = 0; p < NUM_PIX; p++)
      if (idx == IW'(p)) old_count = cnts[p];
  end

  assign new_count = CW'(bfo_pkg::window_step(32'(old_count), enter_bit, leave_bit));

  // R5
  no_wrap_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && leave_bit) |-> (old_count != '0));

  // R5
  no_wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && enter_bit && !leave_bit) |-> (32'(old_count) < OSR));

endmodule

// File: rtl/binfield_oversampler.sv
module binfield_oversampler #(
  parameter int unsigned NUM_PIX = 16,
  parameter int unsigned OSR     = 8,
  localparam int unsigned CW = bfo_pkg::count_bits(OSR),
  localparam int unsigned IW = bfo_pkg::count_bits(NUM_PIX),
  localparam int unsigned SW = bfo_pkg::addr_bits(OSR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_valid,
  input  logic          pix_sof,
  input  logic          pix_bit,
  output logic          out_valid,
  output logic          out_sof,
  output logic [CW-1:0] out_count,
  output logic          out_full
);
  logic          accept;
  logic [IW-1:0] cur_idx;
  logic [SW-1:0] cur_slot;
  logic          cur_full;
  logic          leave_bit;
  logic [CW-1:0] old_count;
  logic [CW-1:0] new_count;

  bfo_raster_track #(.NUM_PIX(NUM_PIX), .OSR(OSR)) u_track (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sof(pix_sof),
    .accept(accept), .cur_idx(cur_idx), .cur_slot(cur_slot), .cur_full(cur_full)
  );

  bfo_history #(.NUM_PIX(NUM_PIX), .OSR(OSR)) u_hist (
    .clk(clk), .rst_n(rst_n), .wr_en(accept), .idx(cur_idx), .slot(cur_slot),
    .new_bit(pix_bit), .leave_bit(leave_bit)
  );

  bfo_counts #(.NUM_PIX(NUM_PIX), .OSR(OSR)) u_cnt (
    .clk(clk), .rst_n(rst_n), .wr_en(accept), .idx(cur_idx),
    .enter_bit(pix_bit), .leave_bit(leave_bit),
    .old_count(old_count), .new_count(new_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_count <= '0;
      out_full  <= 1'b0;
    end else begin
      out_valid <= accept;
      out_sof   <= accept && pix_sof;
      if (accept) begin
        out_count <= new_count;
        out_full  <= cur_full;
      end
    end
  end

  // R2
  out_from_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(pix_valid));

  // R9
  idle_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid);

  // R2
  sof_in_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);

  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(out_count) <= OSR);

  // R6
  ramp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cur_full) |-> (32'(new_count) <= 32'(cur_slot) + 1));

  // R4
  leave_zero_ramp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cur_full) |-> !leave_bit);

endmodule

// File: tb/binfield_oversampler_bench.sv
module binfield_oversampler_bench;
  localparam int NP   = 4;
  localparam int OSR  = 5;
  localparam int CW   = $clog2(OSR + 1);
  localparam int MAXF = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_valid = 1'b0;
  logic pix_sof = 1'b0;
  logic pix_bit = 1'b0;
  logic out_valid, out_sof, out_full;
  logic [CW-1:0] out_count;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;
  int fld = -1;
  bit bits_m [NP][MAXF];

  always #10 clk = ~clk;

  binfield_oversampler #(.NUM_PIX(NP), .OSR(OSR)) u_binfield_oversampler (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sof(pix_sof),
    .pix_bit(pix_bit), .out_valid(out_valid), .out_sof(out_sof),
    .out_count(out_count), .out_full(out_full)
  );

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit pattern(input int mode, input int f, input int p);
    case (mode)
      0: return 1'b1;
      1: return 1'b0;
      2: return ((f + p) % 2) == 0;
      default: return (((f * 7) ^ (p * 13) ^ (f * p)) % 3) == 1;
    endcase
  endfunction

  function automatic int window_sum(input int p);
    int s = 0;
    int lo = (fld - OSR + 1 < 0) ? 0 : fld - OSR + 1;
    for (int f = lo; f <= fld; f++) s += bits_m[p][f];
    return s;
  endfunction

  // Send one pixel that should be accepted, check its output beat
  task automatic send_pix(input bit s, input bit b, input int p);
    pix_valid = 1'b1; pix_sof = s; pix_bit = b;
    bits_m[p][fld] = b;
    @(negedge clk);
    check("R2 valid", out_valid, 1);
    check("R2 sof", out_sof, s);
    check("R3 count", out_count, window_sum(p));
    check("R6 full", out_full, (fld + 1 >= OSR) ? 1 : 0);
  endtask

  // Send a pixel that must be ignored (R7 / R8)
  task automatic send_stray(input string req, input bit b);
    pix_valid = 1'b1; pix_sof = 1'b0; pix_bit = b;
    @(negedge clk);
    check(req, out_valid, 0);
  endtask

  task automatic idle(input int n);
    pix_valid = 1'b0; pix_sof = 1'b0; pix_bit = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R9 idle", out_valid, 0);
    end
  endtask

  task automatic run_field(input int mode, input bit gaps, input bit extra);
    fld++;
    for (int p = 0; p < NP; p++) begin
      send_pix(p == 0, pattern(mode, fld, p), p);
      if (gaps) idle(1);
    end
    if (extra) send_stray("R8 overrun", 1'b1);
  endtask

  task automatic check_reset_state(input string req);
    check(req, out_valid, 0);
    check(req, out_sof, 0);
    check(req, out_count, 0);
    check(req, out_full, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state("R1 after reset");

    // R7: stray pixels before any field
    for (int i = 0; i < 3; i++) send_stray("R7 pre-field", 1'b1);
    idle(1);

    // R5/R6: fill with ones past the window
    for (int k = 0; k < OSR + 2; k++) run_field(0, 1'b0, 1'b0);
    idle(2);
    // R4: steady ones window keeps count at OSR
    run_field(0, 1'b1, 1'b0);
    // decay to zero
    for (int k = 0; k < OSR + 1; k++) run_field(1, 1'b0, k == 2);
    idle(1);
    // alternating and scrambled patterns, R8 overruns in between
    for (int k = 0; k < 8; k++) run_field(2, k[0], k == 3);
    for (int k = 0; k < 16; k++) run_field(3, k[1], k % 5 == 0);
    idle(3);

    // R10: mid-run reset
    pix_valid = 1'b1; pix_sof = 1'b1; pix_bit = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    pix_valid = 1'b0; pix_sof = 1'b0; pix_bit = 1'b0;
    @(negedge clk);
    check_reset_state("R10 reset");
    rst_n = 1'b1;
    fld = -1;
    for (int p = 0; p < NP; p++)
      for (int f = 0; f < MAXF; f++) bits_m[p][f] = 1'b0;
    send_stray("R10 R7 pre-field", 1'b1);
    for (int k = 0; k < OSR + 3; k++) run_field(3, 1'b0, 1'b0);
    run_field(0, 1'b0, 1'b0);
    idle(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule